// File: doc/BRIEF.md
# Interval Timer Prescaler

This block is a binary ripple-free divider chain that produces a periodic timer output, a one-cycle tick and a maskable interrupt, and supplies a prescaled clock to neighbouring timers, a serial port and a watchdog. The divider can be advanced either by a slow sub-clock or by the system clock. A four-bit field picks which divider stage drives the output, so the interval can be set in powers of two.

The tapped stage is carried into the system-clock domain through a two-flop synchronizer, and an edge detector turns its rising edge into a single-cycle tick. During deep sleep, with the system oscillator stopped, the output and the tick are held low. The divider and the interrupt-pending flag live in the divider-clock domain, so an interrupt can still be raised from the sub-clock while the system clock is idle. A bypass control decides whether the sub-clock that leaves the block is the raw sub-clock or the divided stage.

The source select is expected to change only while reset is held. The interrupt clear is sampled on the divider clock and must therefore be held for at least one divider-clock period.

Top module: `interval_prescaler`

## Requirements
- R1: The divider has 14 stages; with tap select n (0 to 13), the output `tOut` has a period of 2^(n+1) divider-clock cycles and stays high for 2^n of them.
- R2: Tap select values 14 and 15 behave exactly like value 13 (period 16384, high time 8192).
- R3: `srcSel` = 0 advances the divider on the sub-clock `subClk`; `srcSel` = 1 advances it on the system clock `sysClk`.
- R4: `tOut` is the tapped stage after two system-clock flops; `tick` is high for exactly one system-clock cycle, in the cycle where `tOut` rises.
- R5: While `sleep` = 1, `tOut` and `tick` are 0, the divider keeps counting, and the pending flag still sets.
- R6: The pending flag sets on every rising edge of the selected stage and stays set until `irqClr` = 1 is sampled on a divider-clock edge; when a set and a clear meet on the same edge, the set wins.
- R7: `irq` equals the pending flag AND `irqMask`; with `irqMask` = 0 the output is 0 but the pending flag is kept.
- R8: With `bypass` = 1, `subClkOut` equals `subClk`; with `bypass` = 0, `subClkOut` is the selected divider stage.
- R9: A synchronous `rst` clears the divider, the synchronizer and the pending flag, so `tOut`, `tick` and `irq` are 0 right after reset.
- R10: Changing the tap select does not reset the divider count; the new stage takes effect from the next divider clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sysClk | input | 1 | System clock; clocks the synchronizer and edge detector |
| subClk | input | 1 | Slow sub-clock, one of the two divider sources |
| rst | input | 1 | Synchronous reset, active high, held across both clocks |
| srcSel | input | 1 | Divider source: 0 sub-clock, 1 system clock |
| tapSel | input | 4 | Divider stage driving the output (14 and 15 act as 13) |
| sleep | input | 1 | Deep sleep: forces output and tick low |
| irqMask | input | 1 | Interrupt enable, 1 passes the pending flag |
| irqClr | input | 1 | Clear request for the pending flag, sampled on divider clock |
| bypass | input | 1 | 1 passes raw sub-clock to `subClkOut`, 0 passes divider stage |
| tOut | output | 1 | Synchronized timer output |
| tick | output | 1 | One-cycle pulse on each rise of `tOut` |
| irq | output | 1 | Masked interrupt request |
| subClkOut | output | 1 | Sub-clock supplied downstream |

## Verification
The two functions that can meet on one edge are the setting of the pending flag by a rising stage and its clearing by `irqClr`. The bench provokes this by selecting the fastest stage on the system clock, where a rise arrives every second edge, and holding the clear high for twenty cycles; with set priority the interrupt must be seen high on roughly half of those cycles, while a clear-priority design would show none. A separate single clear issued just after a tick, far from the next rise, must drop the interrupt and a later rise must raise it again.

// File: rtl/ips_pkg.sv
package ips_pkg;

  localparam int STAGES      = 14;
  localparam int TAP_W       = 4;
  localparam int SYNC_STAGES = 2;

  // Control to datapath strobes
  typedef struct packed {
    logic [TAP_W-1:0] tapIdx;   // clamped stage index
    logic             holdLow;  // force synchronized output low
  } ipsCmd_t;

  // Datapath to control status
  typedef struct packed {
    logic tapLevel;  // raw level of selected stage (divider domain)
    logic tapRise;   // selected stage rises at the next divider edge
    logic outLevel;  // synchronized, sleep-gated level
    logic outRise;   // one-cycle rise of the synchronized level
  } ipsStat_t;

endpackage

// File: rtl/ips_clk_sel.sv
module ips_clk_sel (
  input  logic sysClk,
  input  logic subClk,
  input  logic srcSel,
  output logic divClk
);

  // Static select: only changed while reset is held.
  assign divClk = srcSel ? sysClk : subClk;

endmodule

// File: rtl/ips_datapath.sv
module ips_datapath
  import ips_pkg::*;
#(
  parameter int NUM_STAGES = STAGES,
  parameter int SYNC_DEPTH = SYNC_STAGES
) (
  input  logic     divClk,
  input  logic     sysClk,
  input  logic     rst,
  input  ipsCmd_t  cmd,
  output ipsStat_t stat
);

  logic [NUM_STAGES-1:0] count;
  logic [NUM_STAGES-1:0] countNext;
  logic                  tapLevel;
  logic                  tapNext;

  assign countNext = count + 1'b1;

  always_ff @(posedge divClk) begin
    if (rst) count <= '0;
    else     count <= countNext;
  end

  // Stage select: one-hot per stage, reduced by OR
  logic [NUM_STAGES-1:0] hitNow;
  logic [NUM_STAGES-1:0] hitNext;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_tap
    assign hitNow[s]  = (cmd.tapIdx == s[TAP_W-1:0]) & count[s];
    assign hitNext[s] = (cmd.tapIdx == s[TAP_W-1:0]) & countNext[s];
  end

  assign tapLevel = |hitNow;
  assign tapNext  = |hitNext;

  // Synchronizer into system clock domain plus edge-detect flop
  logic [SYNC_DEPTH-1:0] syncQ;
  logic                  edgeQ;
  logic                  syncLevel;

  always_ff @(posedge sysClk) begin
    if (rst) begin
      syncQ <= '0;
      edgeQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_DEPTH-2:0], tapLevel};
      edgeQ <= syncQ[SYNC_DEPTH-1];
    end
  end

  assign syncLevel = syncQ[SYNC_DEPTH-1];

  always_comb begin
    stat.tapLevel = tapLevel;
    stat.tapRise  = tapNext & ~tapLevel;
    stat.outLevel = syncLevel & ~cmd.holdLow;
    stat.outRise  = syncLevel & ~edgeQ & ~cmd.holdLow;
  end

endmodule

// File: rtl/ips_control.sv
module ips_control
  import ips_pkg::*;
#(
  parameter int NUM_STAGES = STAGES
) (
  input  logic             divClk,
  input  logic             rst,
  input  logic [TAP_W-1:0] tapSel,
  input  logic             sleep,
  input  logic             irqMask,
  input  logic             irqClr,
  input  logic             bypass,
  input  logic             subClk,
  input  ipsStat_t         stat,
  output ipsCmd_t          cmd,
  output logic             tOut,
  output logic             tick,
  output logic             irq,
  output logic             subClkOut
);

  localparam logic [TAP_W-1:0] TOP_TAP = TAP_W'(NUM_STAGES - 1);

  always_comb begin
    cmd.tapIdx  = (tapSel > TOP_TAP) ? TOP_TAP : tapSel;
    cmd.holdLow = sleep;
  end

  // Pending flag in divider domain; set has priority over clear
  logic pend;

  always_ff @(posedge divClk) begin
    if (rst)               pend <= 1'b0;
    else if (stat.tapRise) pend <= 1'b1;
    else if (irqClr)       pend <= 1'b0;
  end

  assign irq       = pend & irqMask;
  assign tOut      = stat.outLevel;
  assign tick      = stat.outRise;
  assign subClkOut = bypass ? subClk : stat.tapLevel;

endmodule

// File: rtl/interval_prescaler.sv
module interval_prescaler
  import ips_pkg::*;
(
  input  logic             sysClk,
  input  logic             subClk,
  input  logic             rst,
  input  logic             srcSel,
  input  logic [TAP_W-1:0] tapSel,
  input  logic             sleep,
  input  logic             irqMask,
  input  logic             irqClr,
  input  logic             bypass,
  output logic             tOut,
  output logic             tick,
  output logic             irq,
  output logic             subClkOut
);

  logic     divClk;
  ipsCmd_t  cmd;
  ipsStat_t stat;

  ips_clk_sel uClk (
    .sysClk (sysClk),
    .subClk (subClk),
    .srcSel (srcSel),
    .divClk (divClk)
  );

  ips_datapath #(
    .NUM_STAGES (STAGES),
    .SYNC_DEPTH (SYNC_STAGES)
  ) uDp (
    .divClk (divClk),
    .sysClk (sysClk),
    .rst    (rst),
    .cmd    (cmd),
    .stat   (stat)
  );

  ips_control #(
    .NUM_STAGES (STAGES)
  ) uCtl (
    .divClk    (divClk),
    .rst       (rst),
    .tapSel    (tapSel),
    .sleep     (sleep),
    .irqMask   (irqMask),
    .irqClr    (irqClr),
    .bypass    (bypass),
    .subClk    (subClk),
    .stat      (stat),
    .cmd       (cmd),
    .tOut      (tOut),
    .tick      (tick),
    .irq       (irq),
    .subClkOut (subClkOut)
  );

endmodule

// File: rtl/ips_checker.sv
module ips_checker (
  input logic sysClk,
  input logic subClk,
  input logic rst,
  input logic sleep,
  input logic irqMask,
  input logic bypass,
  input logic tOut,
  input logic tick,
  input logic irq,
  input logic subClkOut
);

  AST_TICK_SINGLE: assert property (@(posedge sysClk) disable iff (rst)
    tick |=> !tick);  // R4

  AST_RISE_TICKS: assert property (@(posedge sysClk) disable iff (rst)
    ($rose(tOut) && !sleep && !$past(sleep)) |-> tick);  // R4

  AST_SLEEP_QUIET: assert property (@(posedge sysClk) disable iff (rst)
    sleep |-> (!tOut && !tick));  // R5

  AST_MASK_BLOCKS: assert property (@(posedge sysClk) disable iff (rst)
    !irqMask |-> !irq);  // R7

  AST_BYPASS_PASS: assert property (@(posedge sysClk) disable iff (rst)
    bypass |-> (subClkOut == subClk));  // R8

endmodule

bind interval_prescaler ips_checker uChk (
  .sysClk    (sysClk),
  .subClk    (subClk),
  .rst       (rst),
  .sleep     (sleep),
  .irqMask   (irqMask),
  .bypass    (bypass),
  .tOut      (tOut),
  .tick      (tick),
  .irq       (irq),
  .subClkOut (subClkOut)
);

// File: tb/interval_prescaler_test.sv
`timescale 1ns/1ps
module interval_prescaler_test;

  logic       sysClk = 1'b0;
  logic       subClk = 1'b0;
  logic       rst = 1'b1;
  logic       srcSel = 1'b1;
  logic [3:0] tapSel = 4'd0;
  logic       sleep = 1'b0;
  logic       irqMask = 1'b0;
  logic       irqClr = 1'b0;
  logic       bypass = 1'b0;
  logic       tOut, tick, irq, subClkOut;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int tickLowOut = 0;

  always #2  sysClk = ~sysClk;   // 250 MHz
  always #20 subClk = ~subClk;   // 10 system cycles per period

  interval_prescaler uut (
    .sysClk (sysClk), .subClk (subClk), .rst (rst), .srcSel (srcSel),
    .tapSel (tapSel), .sleep (sleep), .irqMask (irqMask), .irqClr (irqClr),
    .bypass (bypass), .tOut (tOut), .tick (tick), .irq (irq),
    .subClkOut (subClkOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic stepN(input int n);
    repeat (n) @(negedge sysClk);
  endtask

  task automatic doReset();
    rst = 1'b1;
    stepN(30);
    rst = 1'b0;
  endtask

  task automatic waitTick(input int limit, output int n);
    n = 0;
    while (n < limit) begin
      @(negedge sysClk);
      n++;
      if (tick) break;
    end
  endtask

  // from a tick cycle: period to the next tick and high cycles of tOut
  task automatic measure(output int per, output int hi);
    per = 0;
    hi = 1;
    forever begin
      @(negedge sysClk);
      per++;
      if (tick) break;
      if (tOut) hi++;
      if (per > 40000) break;
    end
  endtask

  always @(negedge sysClk) if (!rst && tick && !tOut) tickLowOut++;

  initial begin
    int n, per, hi, cnt, rises;
    bit prev;

    // R9: reset state
    srcSel = 1'b1; tapSel = 4'd5; irqMask = 1'b1;
    doReset();
    check(tOut == 0, "R9 tOut after reset", tOut, 0);
    check(tick == 0, "R9 tick after reset", tick, 0);
    check(irq == 0,  "R9 irq after reset", irq, 0);

    // R1 / R2: sweep all tap values on the system clock
    irqMask = 1'b0;
    for (int t = 0; t < 16; t++) begin
      int e;
      e = (t > 13) ? 13 : t;
      tapSel = t[3:0];
      doReset();
      waitTick(20000, n);
      check(tick == 1, (t > 13) ? "R2 first tick" : "R1 first tick", tick, 1);
      measure(per, hi);
      check(per == (2 << e), (t > 13) ? "R2 period" : "R1 period", per, 2 << e);
      check(hi == (1 << e), (t > 13) ? "R2 high time" : "R1 high time", hi, 1 << e);
    end
    check(tickLowOut == 0, "R4 tick only with tOut high", tickLowOut, 0);

    // R3: sub-clock source
    srcSel = 1'b0; tapSel = 4'd0;
    doReset();
    waitTick(1000, n);
    measure(per, hi);
    check(per >= 19 && per <= 21, "R3 sub-clock tap0 period", per, 20);
    tapSel = 4'd1;
    doReset();
    waitTick(1000, n);
    measure(per, hi);
    check(per >= 39 && per <= 41, "R3 sub-clock tap1 period", per, 40);

    // R8: bypass
    bypass = 1'b1; cnt = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge sysClk);
      if (subClkOut != subClk) cnt++;
    end
    check(cnt == 0, "R8 bypass follows subClk", cnt, 0);
    bypass = 1'b0; tapSel = 4'd0; rises = 0; prev = subClkOut;
    for (int i = 0; i < 400; i++) begin
      @(negedge sysClk);
      if (subClkOut && !prev) rises++;
      prev = subClkOut;
    end
    check(rises >= 19 && rises <= 21, "R8 divided subClkOut rises", rises, 20);

    // R5: sleep
    srcSel = 1'b1; tapSel = 4'd2; irqMask = 1'b1;
    doReset();
    sleep = 1'b1; cnt = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge sysClk);
      if (tOut || tick) cnt++;
    end
    check(cnt == 0, "R5 output quiet in sleep", cnt, 0);
    check(irq == 1, "R5 interrupt set in sleep", irq, 1);
    sleep = 1'b0;
    waitTick(30, n);
    check(tick == 1, "R5 tick returns after sleep", tick, 1);

    // R7: mask
    irqMask = 1'b0;
    doReset();
    cnt = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge sysClk);
      if (irq) cnt++;
    end
    check(cnt == 0, "R7 masked irq low", cnt, 0);
    irqMask = 1'b1; #0.5;
    check(irq == 1, "R7 pending kept under mask", irq, 1);

    // R6: clear and set/clear collision
    tapSel = 4'd5;
    doReset();
    waitTick(200, n);
    irqClr = 1'b1; stepN(2); irqClr = 1'b0; stepN(2);
    check(irq == 0, "R6 clear drops irq", irq, 0);
    waitTick(200, n);
    stepN(1);
    check(irq == 1, "R6 next rise sets irq", irq, 1);
    tapSel = 4'd0;
    stepN(4);
    irqClr = 1'b1; cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge sysClk);
      if (irq) cnt++;
    end
    irqClr = 1'b0;
    check(cnt >= 8 && cnt <= 12, "R6 set wins over clear", cnt, 10);

    // R10: tap change keeps the count
    tapSel = 4'd4;
    doReset();
    stepN(600);
    tapSel = 4'd10;
    waitTick(2000, n);
    check(n >= 380 && n <= 470, "R10 tap change without reset", n, 424);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge sysClk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule